// File: doc/BRIEF.md
# PRBS7 Nibble Self-Test Generator and Checker

This block adds a built-in self-test to a 4-bit parallel datapath. One enable input, `testEn`, starts a pattern generator and a pattern checker together. While `testEn` is high, the generator takes the place of the normal transmit nibbles with a pseudorandom sequence of period 127. It produces four sequence bits per clock. While `testEn` is low, transmit data passes through unchanged.

The checker watches the received nibble stream and synchronizes to it by itself. It fills its own local register from the first two received nibbles. From then on it predicts every later nibble with a free-running local generator. It raises a pass flag once enough consecutive nibbles match. A mismatch pulls the pass flag low for a fixed two-cycle window. A long run of mismatches makes the checker start acquisition again. In normal use the transmit output is looped back, through an external path or through the link, into the receive input.

Top module: `nibble_prbs_bist`

## Requirements
- R1: While `testEn` is low, `txDataOut` equals `txDataIn` in the same cycle, and `prbsPass` is low. Dropping `testEn` pulls `prbsPass` low in that same cycle.
- R2: While `testEn` is high, `txDataOut` carries the sequence b[n] = b[n-6] XOR b[n-7], which is the polynomial x^7 + x^6 + 1. Each clock emits four bits. Bit 0 of the nibble is the earliest bit and bit 3 the latest. `txDataIn` has no effect on the output.
- R3: Whenever `testEn` goes high, the generator restarts from its seed. The seven bits before the first emitted bit are all ones (default seed 7'h7F, with seed bit 0 as the most recent bit). The first two nibbles are therefore 4'b0000 and 4'b0100.
- R4: The checker loads its history from the first two received nibbles after enable. It then needs 16 consecutive matching nibbles. With a clean loopback, `prbsPass` is low after the 17th rising clock edge following enable and high after the 18th.
- R5: A single mismatching nibble, received after lock, makes `prbsPass` low for exactly the two cycles that follow the edge where it was sampled. Lock is kept, so `prbsPass` is high again on the third cycle.
- R6: Seven consecutive mismatching nibbles do not cause a reseed: `prbsPass` returns two cycles after the last bad nibble. Eight consecutive mismatching nibbles do cause a reseed: `prbsPass` then stays low until 18 further clean edges have passed.
- R7: A mismatching nibble during acquisition, before lock, restarts the count of 16 matching nibbles.
- R8: An all-zero history in the checker counts as a mismatch, so an all-zero received stream never raises `prbsPass`.
- R9: Out of reset, `prbsPass` is low and `txDataOut` follows `txDataIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the transmit and receive sides |
| rstN | input | 1 | Asynchronous active-low reset |
| testEn | input | 1 | Self-test enable for both generator and checker |
| txDataIn | input | 4 | Normal transmit nibble, bit 0 earliest |
| txDataOut | output | 4 | Transmit nibble: either the pass-through data or the pattern |
| rxDataIn | input | 4 | Received nibble, bit 0 earliest |
| prbsPass | output | 1 | High while the received pattern is locked and error-free |

## Verification
The embedded properties check the following on every cycle:
- the bit recurrence across generator nibbles;
- that the generator state is never zero;
- that a mismatch is followed by two low cycles of the pass flag;
- that the run of mismatches never exceeds the reseed limit;
- that the pass flag rises only while test mode has stayed on.

Only the bench scenarios can show the exact acquisition time of 18 edges, and that lock is retained after seven bad nibbles but lost after eight. The same holds for the restart of the count after an error during acquisition, for the rejection of an all-zero stream, and for the restart from the seed after re-enable. A scoreboard compares every generated nibble against a model of the sequence built from the recurrence.

// File: rtl/nprbs_pkg.sv
package nprbs_pkg;

  localparam int PRBS_W = 7;
  localparam int NIB_W  = 4;
  // feedback taps, as delays in bits
  localparam int TAP_NEAR = 6;
  localparam int TAP_FAR  = 7;

  typedef logic [PRBS_W-1:0] prbsState_t;
  typedef logic [NIB_W-1:0]  nibble_t;

  // strobes from checker control to checker datapath
  typedef struct packed {
    logic seedShift;
    logic compare;
  } chkStrobe_t;

  typedef enum logic [1:0] {
    PH_SEED_A = 2'd0,
    PH_SEED_B = 2'd1,
    PH_CHECK  = 2'd2
  } chkPhase_t;

  // state bit k holds the bit emitted k+1 positions ago
  function automatic prbsState_t prbsShift(prbsState_t h, logic b);
    return {h[PRBS_W-2:0], b};
  endfunction

  function automatic logic prbsBit(prbsState_t h);
    return h[TAP_NEAR-1] ^ h[TAP_FAR-1];
  endfunction

  function automatic nibble_t prbsNibble(prbsState_t h);
    nibble_t    n;
    prbsState_t t;
    t = h;
    for (int i = 0; i < NIB_W; i++) begin
      n[i] = prbsBit(t);
      t    = prbsShift(t, n[i]);
    end
    return n;
  endfunction

  function automatic prbsState_t prbsAdvance(prbsState_t h);
    prbsState_t t;
    t = h;
    for (int i = 0; i < NIB_W; i++) t = prbsShift(t, prbsBit(t));
    return t;
  endfunction

  function automatic prbsState_t prbsLoad(prbsState_t h, nibble_t n);
    prbsState_t t;
    t = h;
    for (int i = 0; i < NIB_W; i++) t = prbsShift(t, n[i]);
    return t;
  endfunction

endpackage

// File: rtl/nprbs_gen.sv
module nprbs_gen
  import nprbs_pkg::*;
#(
  parameter prbsState_t SEED = 7'h7F
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    testEn,
  input  nibble_t txDataIn,
  output nibble_t txDataOut
);

  prbsState_t genState;
  nibble_t    genNibble;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        genState <= SEED;
    else if (!testEn) genState <= SEED;
    else              genState <= prbsAdvance(genState);
  end

  assign genNibble = prbsNibble(genState);
  assign txDataOut = testEn ? genNibble : txDataIn;

  // R2
  gen_state_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    genState != '0);

  // R2
  gen_recurrence_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && $past(testEn, 1) && $past(testEn, 2)) |->
      (txDataOut[0] == ($past(txDataOut[2], 2) ^ $past(txDataOut[1], 2)) &&
       txDataOut[1] == ($past(txDataOut[3], 2) ^ $past(txDataOut[2], 2))));

endmodule

// File: rtl/nprbs_chk_dp.sv
module nprbs_chk_dp
  import nprbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  chkStrobe_t strobe,
  input  nibble_t    rxDataIn,
  output logic       nibErr
);

  prbsState_t hist;
  nibble_t    predNibble;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hist <= '0;
    else if (strobe.seedShift) hist <= prbsLoad(hist, rxDataIn);
    else if (strobe.compare)   hist <= prbsAdvance(hist);
  end

  assign predNibble = prbsNibble(hist);
  // a zero history can never be a valid lock
  assign nibErr = strobe.compare && ((rxDataIn != predNibble) || (hist == '0));

  // R8
  zero_hist_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && hist == '0) |-> nibErr);

endmodule

// File: rtl/nprbs_chk_ctrl.sv
module nprbs_chk_ctrl
  import nprbs_pkg::*;
#(
  parameter int LOCK_COUNT   = 16,
  parameter int RESEED_COUNT = 8,
  parameter int HOLD_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic       nibErr,
  output chkStrobe_t strobe,
  output logic       prbsPass
);

  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam int BAD_W  = $clog2(RESEED_COUNT + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  chkPhase_t         phase;
  logic              locked;
  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;
  logic [HOLD_W-1:0] errHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_SEED_A;
      locked  <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
      errHold <= '0;
    end else if (!testEn) begin
      phase   <= PH_SEED_A;
      locked  <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
      errHold <= '0;
    end else begin
      errHold <= (errHold != '0) ? errHold - 1'b1 : '0;
      case (phase)
        PH_SEED_A: phase <= PH_SEED_B;
        PH_SEED_B: phase <= PH_CHECK;
        default: begin
          if (nibErr) begin
            errHold <= HOLD_W'(HOLD_CYCLES);
            goodCnt <= '0;
            if (badCnt == BAD_W'(RESEED_COUNT - 1)) begin
              phase  <= PH_SEED_A;
              locked <= 1'b0;
              badCnt <= '0;
            end else begin
              badCnt <= badCnt + 1'b1;
            end
          end else begin
            badCnt <= '0;
            if (!locked) begin
              if (goodCnt == GOOD_W'(LOCK_COUNT - 1)) begin
                locked  <= 1'b1;
                goodCnt <= '0;
              end else begin
                goodCnt <= goodCnt + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.seedShift = testEn && (phase != PH_CHECK);
    strobe.compare   = testEn && (phase == PH_CHECK);
  end

  assign prbsPass = testEn && locked && (errHold == '0);

  // R5
  err_low_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    nibErr |=> !prbsPass);

  // R5
  err_low_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(nibErr, 2) && $past(testEn, 1) && testEn) |-> !prbsPass);

  // R6
  bad_run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    badCnt < BAD_W'(RESEED_COUNT));

  // R4
  pass_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prbsPass) |-> ($past(testEn) && $past(strobe.compare)));

endmodule

// File: rtl/nibble_prbs_bist.sv
module nibble_prbs_bist
  import nprbs_pkg::*;
#(
  parameter logic [6:0] SEED         = 7'h7F,
  parameter int         LOCK_COUNT   = 16,
  parameter int         RESEED_COUNT = 8,
  parameter int         HOLD_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic [3:0] txDataIn,
  output logic [3:0] txDataOut,
  input  logic [3:0] rxDataIn,
  output logic       prbsPass
);

  chkStrobe_t chkStrobe;
  logic       nibErr;

  nprbs_gen #(.SEED(SEED)) uGen (
    .clk       (clk),
    .rstN      (rstN),
    .testEn    (testEn),
    .txDataIn  (txDataIn),
    .txDataOut (txDataOut)
  );

  nprbs_chk_dp uChkDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (chkStrobe),
    .rxDataIn (rxDataIn),
    .nibErr   (nibErr)
  );

  nprbs_chk_ctrl #(
    .LOCK_COUNT   (LOCK_COUNT),
    .RESEED_COUNT (RESEED_COUNT),
    .HOLD_CYCLES  (HOLD_CYCLES)
  ) uChkCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .testEn   (testEn),
    .nibErr   (nibErr),
    .strobe   (chkStrobe),
    .prbsPass (prbsPass)
  );

  // R1
  pass_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> !prbsPass);

endmodule

// File: tb/tb_nibble_prbs_bist.sv
`timescale 1ns/1ps
module tb_nibble_prbs_bist;

  logic       clk = 1'b0;
  logic       rstN;
  logic       testEn;
  logic [3:0] txDataIn;
  logic [3:0] txDataOut;
  logic [3:0] rxDataIn;
  logic       prbsPass;
  logic [3:0] flip;
  logic       zeroRx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] expQ[$];
  bit         modelBits[$];

  always #5 clk = ~clk;

  assign rxDataIn = zeroRx ? 4'h0 : (txDataOut ^ flip);

  nibble_prbs_bist dut (
    .clk(clk), .rstN(rstN), .testEn(testEn), .txDataIn(txDataIn),
    .txDataOut(txDataOut), .rxDataIn(rxDataIn), .prbsPass(prbsPass)
  );

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected sequence model: seed of all ones, b[n] = b[n-6] ^ b[n-7]
  task automatic modelReset();
    modelBits.delete();
    for (int i = 0; i < 7; i++) modelBits.push_back(1'b1);
  endtask

  function automatic logic [3:0] modelNext();
    logic [3:0] n;
    for (int i = 0; i < 4; i++) begin
      int sz = modelBits.size();
      n[i] = modelBits[sz-6] ^ modelBits[sz-7];
      modelBits.push_back(n[i]);
      void'(modelBits.pop_front());
    end
    return n;
  endfunction

  // driver: one cycle, pushing the expected transmit nibble while enabled
  task automatic tick();
    if (testEn) expQ.push_back(modelNext());
    txDataIn = txDataIn + 4'd5;
    @(negedge clk);
    #1;
  endtask

  task automatic enableTest();
    modelReset();
    expQ.delete();
    testEn = 1'b1;
  endtask

  task automatic disableTest();
    testEn = 1'b0;
    expQ.delete();
  endtask

  // monitor: compare transmit nibbles just before the rising edge
  always @(negedge clk) begin
    #4;
    if (testEn && expQ.size() > 0) begin
      logic [3:0] e;
      e = expQ.pop_front();
      checkEq("R2/R3 sequence", txDataOut, e);
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; testEn = 1'b0; txDataIn = 4'h3; flip = 4'h0; zeroRx = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    checkEq("R9 pass in reset", prbsPass, 0);
    checkEq("R9 passthrough in reset", txDataOut, txDataIn);
    rstN = 1'b1;

    // R1 disabled passthrough
    for (int i = 0; i < 4; i++) begin
      tick();
      checkEq("R1 passthrough", txDataOut, txDataIn);
      checkEq("R1 pass low", prbsPass, 0);
    end

    // R4 acquisition timing, R3 first nibbles
    enableTest();
    #0;
    checkEq("R3 first nibble", txDataOut, 4'b0000);
    for (int i = 0; i < 17; i++) tick();
    checkEq("R4 pass low after 17 edges", prbsPass, 0);
    tick();
    checkEq("R4 pass high after 18 edges", prbsPass, 1);
    for (int i = 0; i < 10; i++) tick();
    checkEq("R4 pass held", prbsPass, 1);

    // R5 single error
    flip = 4'b0010;
    tick();
    flip = 4'h0;
    checkEq("R5 low cycle 1", prbsPass, 0);
    tick();
    checkEq("R5 low cycle 2", prbsPass, 0);
    tick();
    checkEq("R5 high again", prbsPass, 1);
    for (int i = 0; i < 5; i++) tick();

    // R6 seven bad nibbles keep lock
    flip = 4'b1000;
    for (int i = 0; i < 7; i++) begin
      tick();
      checkEq("R6 low during errors", prbsPass, 0);
    end
    flip = 4'h0;
    tick();
    checkEq("R6 seven: low +1", prbsPass, 0);
    tick();
    checkEq("R6 seven: lock kept", prbsPass, 1);
    for (int i = 0; i < 5; i++) tick();

    // R6 eight bad nibbles force reseed
    flip = 4'b0001;
    for (int i = 0; i < 8; i++) tick();
    flip = 4'h0;
    for (int i = 0; i < 17; i++) tick();
    checkEq("R6 eight: still low after 17", prbsPass, 0);
    tick();
    checkEq("R6 eight: relocked after 18", prbsPass, 1);

    // R1 disable drops pass at once
    disableTest();
    #1;
    checkEq("R1 pass dropped on disable", prbsPass, 0);
    checkEq("R1 passthrough after disable", txDataOut, txDataIn);
    tick();
    tick();

    // R7 error during acquisition restarts count (also restart from seed)
    enableTest();
    #0;
    checkEq("R3 restart from seed", txDataOut, 4'b0000);
    for (int i = 0; i < 6; i++) tick();
    flip = 4'b0100;
    tick();
    flip = 4'h0;
    for (int i = 0; i < 15; i++) tick();
    checkEq("R7 still acquiring", prbsPass, 0);
    tick();
    checkEq("R7 lock after restarted count", prbsPass, 1);
    disableTest();
    tick();

    // R8 all-zero stream never locks
    zeroRx = 1'b1;
    enableTest();
    for (int i = 0; i < 40; i++) begin
      tick();
      if (i % 10 == 9) checkEq("R8 zero stream rejected", prbsPass, 0);
    end
    disableTest();
    zeroRx = 1'b0;
    tick();
    checkEq("R1 final passthrough", txDataOut, txDataIn);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule